// File: doc/BRIEF.md
# Dual-Storage Pixel Timing Generator

This block produces the control pulses for an image-sensor pixel with two charge stores. The photodiode integrates for a whole frame and is read once at the end of it. The storage diode takes several short integrations inside the same frame, and each of these is read out on its own. All periods come from configuration inputs and are counted in clock cycles: the frame length, the sub-frame length, the row-readout cycle and the separation-gate open time. A sub-frame count sets how many short integrations each frame holds.

A frame runs from the frame-start marker to the photodiode transfer strobe on its last cycle. The frame-start marker also resets the photodiode. The short integrations run back to back from the start of the frame. Each one opens with a storage-diode reset and closes with a storage-diode transfer strobe, which carries that sub-frame's index. While a short integration is active, the separation gate opens at the start of every row cycle. The block clamps its configuration so that the two transfer strobes can never be active together on the shared floating node. It also samples the configuration only when one frame ends and the next begins.

Top module: `dual_store_timing`

## Requirements
- R1: While `rst_n` is low, every output is 0. The first frame-start marker appears in the cycle that follows the first rising clock edge after reset is released.
- R2: The effective frame length is Fe = max(`cfg_frame_len`, 2) cycles. `frame_sof` is high only in frame cycle 0. `pd_xfer` is high only in frame cycle Fe−1, and the next frame starts in the cycle after it.
- R3: Sub-frame k occupies frame cycles k·Se to k·Se+Se−1, where Se = max(`cfg_sub_len`, 2). `sub_active` is high across those cycles. `sd_rst` is high on the first of them and `sd_xfer` on the last.
- R4: `sub_idx` equals k throughout sub-frame k, including the cycle of its `sd_xfer`. It is 0 at frame start.
- R5: The number of sub-frames per frame is min(`cfg_sub_count`, floor((Fe−1)/Se)). Every short integration therefore ends before frame cycle Fe−1, and a count of 0 gives no sub-frames.
- R6: The row cycle has length He = max(`cfg_row_len`, 1). The row position restarts at frame cycle 0. `row_stb` is high when the row position equals He−1.
- R7: `sep_gate` is high exactly when `sub_active` is high and the row position is below min(`cfg_gate_len`, He).
- R8: `pd_xfer` and `sd_xfer` are never high in the same cycle.
- R9: A configuration change takes effect only in the frame that starts after the current frame's `pd_xfer`. The current frame keeps its old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frame_len | input | CW | Frame length in cycles |
| cfg_sub_len | input | CW | Short-integration length in cycles |
| cfg_row_len | input | CW | Row-readout cycle length in cycles |
| cfg_gate_len | input | CW | Separation-gate open cycles per row |
| cfg_sub_count | input | MW | Requested sub-frames per frame |
| frame_sof | output | 1 | Frame start; also resets the photodiode |
| pd_xfer | output | 1 | Photodiode transfer strobe |
| sd_rst | output | 1 | Storage-diode reset, first cycle of a sub-frame |
| sd_xfer | output | 1 | Storage-diode transfer strobe |
| sub_active | output | 1 | Short integration in progress |
| sub_idx | output | MW | Index of the current sub-frame |
| sep_gate | output | 1 | Separation-gate enable |
| row_stb | output | 1 | Row-readout strobe |

## Verification
The hardest situation to reach is a configuration change in the middle of a frame, where the new values must not disturb the timing already running. The stimulus changes every input halfway through a frame. It then checks that frame cycle by cycle against the old timing, and the following frame against the new one. Boundary cases are reached through chosen configurations: sub-frames that exactly fill the frame minus one cycle, one fewer cycle than that, out-of-range gate and count values, and lengths below the clamp limits.

// File: rtl/dual_store_timing.sv
module dual_store_timing #(
  parameter int CW = 16,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_frame_len,
  input  logic [CW-1:0] cfg_sub_len,
  input  logic [CW-1:0] cfg_row_len,
  input  logic [CW-1:0] cfg_gate_len,
  input  logic [MW-1:0] cfg_sub_count,
  output logic          frame_sof,
  output logic          pd_xfer,
  output logic          sd_rst,
  output logic          sd_xfer,
  output logic          sub_active,
  output logic [MW-1:0] sub_idx,
  output logic          sep_gate,
  output logic          row_stb
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic          running, sub_on;
  logic [CW-1:0] fcnt, rcnt, scnt;
  logic [CW-1:0] fe, se, he, pe;
  logic [MW-1:0] me, sidx;

  wire [CW-1:0] fe_in = (cfg_frame_len < TWO) ? TWO : cfg_frame_len;
  wire [CW-1:0] se_in = (cfg_sub_len < TWO) ? TWO : cfg_sub_len;
  wire [CW-1:0] he_in = (cfg_row_len < ONE) ? ONE : cfg_row_len;
  wire [CW-1:0] pe_in = (cfg_gate_len > he_in) ? he_in : cfg_gate_len;

  wire frame_end = running && (fcnt == fe - ONE);
  wire fits      = ({1'b0, fcnt} + {1'b0, se}) < {1'b0, fe};
  wire begin_sub = running && !sub_on && (sidx < me) && fits;
  wire sub_end   = sub_on && (scnt == se - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sub_on  <= 1'b0;
      fcnt    <= '0;
      rcnt    <= '0;
      scnt    <= '0;
      sidx    <= '0;
      fe      <= TWO;
      se      <= TWO;
      he      <= ONE;
      pe      <= '0;
      me      <= '0;
    end else if (!running || frame_end) begin
      running <= 1'b1;
      sub_on  <= 1'b0;
      fcnt    <= '0;
      rcnt    <= '0;
      scnt    <= '0;
      sidx    <= '0;
      fe      <= fe_in;
      se      <= se_in;
      he      <= he_in;
      pe      <= pe_in;
      me      <= cfg_sub_count;
    end else begin
      fcnt <= fcnt + ONE;
      rcnt <= (rcnt == he - ONE) ? '0 : rcnt + ONE;
      if (begin_sub) begin
        sub_on <= 1'b1;
        scnt   <= ONE;
      end else if (sub_end) begin
        sub_on <= 1'b0;
        sidx   <= sidx + 1'b1;
      end else if (sub_on) begin
        scnt <= scnt + ONE;
      end
    end
  end

  assign frame_sof  = running && (fcnt == '0);
  assign pd_xfer    = frame_end;
  assign sd_rst     = begin_sub;
  assign sd_xfer    = sub_end;
  assign sub_active = begin_sub || sub_on;
  assign sub_idx    = sidx;
  assign sep_gate   = sub_active && (rcnt < pe);
  assign row_stb    = running && (rcnt == he - ONE);
endmodule

// File: rtl/dual_store_timing_chk.sv
module dual_store_timing_chk #(
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_sof,
  input logic          pd_xfer,
  input logic          sd_rst,
  input logic          sd_xfer,
  input logic          sub_active,
  input logic [MW-1:0] sub_idx,
  input logic          sep_gate
);
  // R8
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_xfer && sd_xfer));
  // R7
  gate_in_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sep_gate |-> sub_active);
  // R2
  pd_then_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_xfer |=> frame_sof);
  // R4
  idx_zero_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |-> (sub_idx == '0));
  // R3
  rst_then_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_rst |=> (sub_active && !sd_rst));
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_xfer |=> (sub_idx == $past(sub_idx) + 1'b1));
endmodule

bind dual_store_timing dual_store_timing_chk #(.MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sof(frame_sof), .pd_xfer(pd_xfer),
  .sd_rst(sd_rst), .sd_xfer(sd_xfer), .sub_active(sub_active),
  .sub_idx(sub_idx), .sep_gate(sep_gate)
);

// File: tb/dual_store_timing_test.sv
`timescale 1ns/1ps
module dual_store_timing_test;
  localparam int CW = 16;
  localparam int MW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_frame_len = '0, cfg_sub_len = '0, cfg_row_len = '0, cfg_gate_len = '0;
  logic [MW-1:0] cfg_sub_count = '0;
  logic frame_sof, pd_xfer, sd_rst, sd_xfer, sub_active, sep_gate, row_stb;
  logic [MW-1:0] sub_idx;
  int checks = 0;
  int failures = 0;
  int nf, ns, nh, np, nm;

  always #2.5 clk = ~clk;

  dual_store_timing #(.CW(CW), .MW(MW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_frame_len(cfg_frame_len), .cfg_sub_len(cfg_sub_len),
    .cfg_row_len(cfg_row_len), .cfg_gate_len(cfg_gate_len), .cfg_sub_count(cfg_sub_count),
    .frame_sof(frame_sof), .pd_xfer(pd_xfer), .sd_rst(sd_rst), .sd_xfer(sd_xfer),
    .sub_active(sub_active), .sub_idx(sub_idx), .sep_gate(sep_gate), .row_stb(row_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int f, input int s, input int h, input int p, input int m);
    cfg_frame_len = CW'(f); cfg_sub_len = CW'(s); cfg_row_len = CW'(h);
    cfg_gate_len = CW'(p); cfg_sub_count = MW'(m);
  endtask

  // Checks one frame starting at t=0 at a falling edge; optionally switches to n* at chg.
  task automatic run_frame(input int f, input int s, input int h, input int p, input int m,
                           input int chg);
    int fe = (f < 2) ? 2 : f;
    int se = (s < 2) ? 2 : s;
    int he = (h < 1) ? 1 : h;
    int pe = (p > he) ? he : p;
    int mfit = (fe - 1) / se;
    int me = (m < mfit) ? m : mfit;
    for (int t = 0; t < fe; t++) begin
      int k = t / se;
      int ph = t % se;
      int r = t % he;
      bit act = (k < me);
      chk(frame_sof == (t == 0), "R2 frame_sof", frame_sof, t == 0);
      chk(pd_xfer == (t == fe - 1), "R2 pd_xfer", pd_xfer, t == fe - 1);
      chk(sub_active == act, "R3 sub_active", sub_active, act);
      chk(sd_rst == (act && ph == 0), "R3 sd_rst", sd_rst, act && ph == 0);
      chk(sd_xfer == (act && ph == se - 1), "R5 sd_xfer", sd_xfer, act && ph == se - 1);
      if (act) chk(sub_idx == MW'(k), "R4 sub_idx", sub_idx, k);
      chk(row_stb == (r == he - 1), "R6 row_stb", row_stb, r == he - 1);
      chk(sep_gate == (act && r < pe), "R7 sep_gate", sep_gate, act && r < pe);
      chk(!(pd_xfer && sd_xfer), "R8 exclusive", pd_xfer && sd_xfer, 0);
      if (t == chg) set_cfg(nf, ns, nh, np, nm);
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_cfg(30, 6, 4, 2, 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({frame_sof, pd_xfer, sd_rst, sd_xfer, sub_active, sep_gate, row_stb} == '0,
        "R1 outputs in reset", {frame_sof, pd_xfer, sd_rst, sd_xfer, sub_active, sep_gate, row_stb}, 0);
    chk(sub_idx == '0, "R1 sub_idx in reset", sub_idx, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_sof == 1'b1, "R1 first frame start", frame_sof, 1);
    run_frame(30, 6, 4, 2, 3, -1);
    // R9 change mid-frame: current frame keeps old timing
    nf = 25; ns = 6; nh = 5; np = 9; nm = 4;
    run_frame(30, 6, 4, 2, 3, 15);
    run_frame(25, 6, 5, 9, 4, -1);      // R5 exact fit: 4 sub-frames in 24 cycles
    set_cfg(24, 6, 3, 1, 4);
    run_frame(25, 6, 5, 9, 4, -1);      // R9 applies after this frame
    run_frame(24, 6, 3, 1, 4, -1);      // R5 one short: only 3 sub-frames
    nf = 1; ns = 1; nh = 0; np = 0; nm = 2;
    run_frame(24, 6, 3, 1, 4, 10);
    run_frame(1, 1, 0, 0, 2, -1);       // R8 clamps: Fe=2, Se=2, He=1, no sub-frame
    set_cfg(20, 1, 3, 3, 15);
    run_frame(1, 1, 0, 0, 2, -1);
    run_frame(20, 1, 3, 3, 15, -1);     // R5 count capped at 9
    set_cfg(12, 3, 4, 2, 0);
    run_frame(20, 1, 3, 3, 15, -1);
    run_frame(12, 3, 4, 2, 0, -1);      // R5 zero count
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule